// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side controller for a 16-bit sampling converter on a serial link. The link has a convert strobe, a shift clock, a result line from the converter and, optionally, a configuration line to it. A conversion begins when the `start` input pulses, or when an internal sample-rate timer expires while `auto_en` is high. The sequencer raises the convert strobe and holds it high for the conversion time. It then lowers the strobe and waits a setup interval. Next it issues exactly sixteen shift-clock pulses, taking in the result most significant bit first on each rising edge. It finishes with a hold interval and a one-cycle `res_valid` strobe.

When the configuration line is present, two bits are sent in the first two clock periods of the same frame that returns data: first the single-ended flag, then the odd/sign flag. Those bits choose the input for the *next* conversion. Each result is therefore tagged with the word sent one frame earlier, and the first result after reset is marked as having no known channel. All link timings are given in picoseconds as parameters and turned into system-clock counts by rounding up, so minimum timings hold for any system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `adc_conv`, `adc_sck`, `adc_sdi`, `busy` and `res_valid` are all 0. A reset in the middle of a frame abandons that frame.
- R2: A launch raises `adc_conv` in the next cycle and holds it high for exactly CONV_CYC = ceil(T_CONV_PS / CLK_PS) system cycles.
- R3: The first rising edge of `adc_sck` comes exactly SETUP_CYC + SCK_HALF cycles after `adc_conv` falls. SETUP_CYC = max(1, ceil(T_SETUP_PS / CLK_PS)) and SCK_HALF = max(1, ceil(T_SCK_HALF_PS / CLK_PS)).
- R4: Each frame has exactly 16 rising edges of `adc_sck`, spaced 2*SCK_HALF cycles apart. `adc_sck` is high only while `adc_conv` is low.
- R5: The code is assembled from `adc_sdo` sampled on each rising `adc_sck` edge, the first sample becoming bit 15. It appears on `res_code` with a single-cycle `res_valid` pulse.
- R6: `adc_sdi` carries `cfg_single` during the first clock period of the frame, then `cfg_odd` during the second, then 0. Both flags are latched at launch. `adc_sdi` changes only while `adc_sck` is low.
- R7: `res_single`/`res_chan` report the configuration word sent in the previous frame, with `res_chan` being the odd/sign bit. `res_known` is 0 for the first result after reset and 1 afterwards.
- R8: `adc_conv` stays low from the last rising `adc_sck` edge until the frame ends. `res_valid` rises SCK_HALF + HOLD_CYC cycles after that edge, with HOLD_CYC = max(1, ceil(T_HOLD_PS / CLK_PS)), and `busy` is low when it does.
- R9: A `start` pulse while `busy` is high is ignored: it produces no additional conversion.
- R10: With `auto_en` high, conversions start every RATE_CYCLES system cycles, provided a frame is shorter than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion when idle |
| auto_en | input | 1 | Enable periodic conversions from the rate timer |
| cfg_single | input | 1 | Single-ended flag of the next configuration word |
| cfg_odd | input | 1 | Odd/sign flag of the next configuration word |
| busy | output | 1 | High while a frame is in progress |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Shift clock to the converter, idle low |
| adc_sdi | output | 1 | Configuration bits to the converter |
| adc_sdo | input | 1 | Result bits from the converter |
| res_valid | output | 1 | One-cycle strobe: result is ready |
| res_code | output | 16 | Captured conversion code |
| res_chan | output | 1 | Odd/sign bit of the word that chose this result's input |
| res_single | output | 1 | Single-ended bit of the word that chose this result's input |
| res_known | output | 1 | 0 when the result's input selection is unknown |

## Verification
The hardest state to reach is a result whose channel tag is unknown at some point other than power-up. That requires a reset that lands mid-frame, after a word has gone out but before it has been paired with a result. The bench pulses reset while the shift clock is running, then confirms that the next result reports an unknown channel. It also confirms that the result after that carries the word sent in the first frame following the reset. A behavioural converter model counts clock edges to serve the data bits and gather the configuration bits, so bit order and the one-frame tag lag are checked against the model's own view of the link.

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl #(
  parameter int CLK_PS        = 10000,
  parameter int T_CONV_PS     = 4660000,
  parameter int T_SETUP_PS    = 60000,
  parameter int T_HOLD_PS     = 26000,
  parameter int T_SCK_HALF_PS = 62500,
  parameter int RATE_CYCLES   = 2000,
  parameter bit HAS_SDI       = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        auto_en,
  input  logic        cfg_single,
  input  logic        cfg_odd,
  output logic        busy,
  output logic        adc_conv,
  output logic        adc_sck,
  output logic        adc_sdi,
  input  logic        adc_sdo,
  output logic        res_valid,
  output logic [15:0] res_code,
  output logic        res_chan,
  output logic        res_single,
  output logic        res_known
);
  localparam int CONV_RAW  = (T_CONV_PS + CLK_PS - 1) / CLK_PS;
  localparam int SETUP_RAW = (T_SETUP_PS + CLK_PS - 1) / CLK_PS;
  localparam int HOLD_RAW  = (T_HOLD_PS + CLK_PS - 1) / CLK_PS;
  localparam int HALF_RAW  = (T_SCK_HALF_PS + CLK_PS - 1) / CLK_PS;
  localparam int CONV_CYC  = (CONV_RAW  < 1) ? 1 : CONV_RAW;
  localparam int SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int HOLD_CYC  = (HOLD_RAW  < 1) ? 1 : HOLD_RAW;
  localparam int SCK_HALF  = (HALF_RAW  < 1) ? 1 : HALF_RAW;
  localparam int MAX_A     = (CONV_CYC > SETUP_CYC) ? CONV_CYC : SETUP_CYC;
  localparam int MAX_B     = (HOLD_CYC > SCK_HALF) ? HOLD_CYC : SCK_HALF;
  localparam int MAX_CYC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW        = $clog2(MAX_CYC + 1);
  localparam int RW        = $clog2(RATE_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_CONV, ST_SETUP, ST_SHIFT, ST_HOLD} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [3:0]     bitn;
  logic [15:0]    shreg;
  logic [1:0]     word, prev_word, res_word;
  logic           have_prev, known_q, sdi_q;
  logic [RW-1:0]  rate_cnt;
  logic           tick_pend;
  logic           launch;

  assign busy   = (st != ST_IDLE);
  assign launch = (st == ST_IDLE) && (start || tick_pend);

  always_ff @(posedge clk) begin
    if (rst || !auto_en) begin
      rate_cnt  <= '0;
      tick_pend <= 1'b0;
    end else begin
      if (launch) tick_pend <= 1'b0;
      if (rate_cnt == RW'(RATE_CYCLES - 1)) begin
        rate_cnt  <= '0;
        tick_pend <= 1'b1;
      end else begin
        rate_cnt <= rate_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      word      <= '0;
      prev_word <= '0;
      res_word  <= '0;
      have_prev <= 1'b0;
      known_q   <= 1'b0;
      adc_conv  <= 1'b0;
      adc_sck   <= 1'b0;
      sdi_q     <= 1'b0;
      res_valid <= 1'b0;
      res_code  <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        ST_IDLE: if (launch) begin
          st       <= ST_CONV;
          adc_conv <= 1'b1;
          cnt      <= CW'(CONV_CYC - 1);
          word     <= {cfg_single, cfg_odd};
        end
        ST_CONV: if (cnt == '0) begin
          st       <= ST_SETUP;
          adc_conv <= 1'b0;
          cnt      <= CW'(SETUP_CYC - 1);
          sdi_q    <= word[1];
        end else cnt <= cnt - 1'b1;
        ST_SETUP: if (cnt == '0) begin
          st   <= ST_SHIFT;
          cnt  <= CW'(SCK_HALF - 1);
          bitn <= '0;
        end else cnt <= cnt - 1'b1;
        ST_SHIFT: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          cnt <= CW'(SCK_HALF - 1);
          if (!adc_sck) begin
            adc_sck <= 1'b1;
            shreg   <= {shreg[14:0], adc_sdo};
          end else begin
            adc_sck <= 1'b0;
            if (bitn == 4'd15) begin
              st    <= ST_HOLD;
              cnt   <= CW'(HOLD_CYC - 1);
              sdi_q <= 1'b0;
            end else begin
              bitn  <= bitn + 1'b1;
              sdi_q <= (bitn == 4'd0) ? word[0] : 1'b0;
            end
          end
        end
        ST_HOLD: if (cnt == '0) begin
          st        <= ST_IDLE;
          res_valid <= 1'b1;
          res_code  <= shreg;
          res_word  <= prev_word;
          known_q   <= have_prev;
          prev_word <= word;
          have_prev <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  if (HAS_SDI) begin : g_sdi
    assign adc_sdi    = sdi_q;
    assign res_chan   = res_word[0];
    assign res_single = res_word[1];
    assign res_known  = known_q;
  end else begin : g_nosdi
    logic unused_ok;
    assign unused_ok  = ^{sdi_q, res_word, known_q};
    assign adc_sdi    = 1'b0;
    assign res_chan   = 1'b0;
    assign res_single = 1'b0;
    assign res_known  = 1'b1;
  end
endmodule

module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic conv,
  input logic sck,
  input logic sdi,
  input logic valid
);
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!conv && !sck)); // R1
  AST_CONV_RISE_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(conv) |-> $past(!busy)); // R9
  AST_NO_SCK_AT_CONV_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(conv) |-> !sck); // R3
  AST_SCK_ONLY_CONV_LOW: assert property (@(posedge clk) disable iff (rst)
    sck |-> !conv); // R4
  AST_VALID_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R5
  AST_SDI_STABLE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(sdi)); // R6
  AST_VALID_AT_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    valid |-> (!busy && !conv && !sck)); // R8
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .conv(adc_conv),
  .sck(adc_sck), .sdi(adc_sdi), .valid(res_valid)
);

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_PS     = 50000;
  localparam int RATE       = 300;
  localparam int E_CONV  = (4660000 + CLK_PS - 1) / CLK_PS;
  localparam int E_SETUP = ((60000 + CLK_PS - 1) / CLK_PS) < 1 ? 1 : (60000 + CLK_PS - 1) / CLK_PS;
  localparam int E_HOLD  = ((26000 + CLK_PS - 1) / CLK_PS) < 1 ? 1 : (26000 + CLK_PS - 1) / CLK_PS;
  localparam int E_HALF  = ((62500 + CLK_PS - 1) / CLK_PS) < 1 ? 1 : (62500 + CLK_PS - 1) / CLK_PS;
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 1'b0, 16'hA5C3}, {1'b1, 1'b1, 16'h0000}, {1'b0, 1'b0, 16'hFFFF},
    {1'b0, 1'b1, 16'h8001}, {1'b1, 1'b1, 16'h1234}, {1'b1, 1'b0, 16'h7FFE}};

  logic clk = 0, rst = 1, start = 0, auto_en = 0, cfg_single = 0, cfg_odd = 0;
  logic busy, adc_conv, adc_sck, adc_sdi, adc_sdo, res_valid, res_chan, res_single, res_known;
  logic [15:0] res_code;
  logic [15:0] adc_val = 16'h0;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.CLK_PS(CLK_PS), .RATE_CYCLES(RATE)) dut_i (
    .clk(clk), .rst(rst), .start(start), .auto_en(auto_en),
    .cfg_single(cfg_single), .cfg_odd(cfg_odd), .busy(busy),
    .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdi(adc_sdi), .adc_sdo(adc_sdo),
    .res_valid(res_valid), .res_code(res_code), .res_chan(res_chan),
    .res_single(res_single), .res_known(res_known));

  int  fall_cnt = 0, rise_cnt = 0, conv_rises = 0;
  logic [1:0] rxw = 0;
  time t_conv_rise = 0, t_prev_rise = 0, t_conv_fall = 0, t_first = 0, t_last = 0;
  time per_min = 0, per_max = 0;

  assign adc_sdo = (fall_cnt < 16) ? adc_val[15 - fall_cnt] : 1'b0;

  always @(posedge adc_conv or negedge adc_sck)
    if (adc_conv) fall_cnt <= 0; else fall_cnt <= fall_cnt + 1;

  always @(posedge adc_conv or posedge adc_sck)
    if (adc_conv) begin
      rise_cnt <= 0; rxw <= 2'b00; per_min <= 64'hFFFF; per_max <= 0;
    end else begin
      if (rise_cnt < 2) rxw <= {rxw[0], adc_sdi};
      if (rise_cnt == 0) t_first <= $time;
      else begin
        if ($time - t_last < per_min) per_min <= $time - t_last;
        if ($time - t_last > per_max) per_max <= $time - t_last;
      end
      t_last   <= $time;
      rise_cnt <= rise_cnt + 1;
    end

  always @(posedge adc_conv) begin
    t_prev_rise <= t_conv_rise; t_conv_rise <= $time; conv_rises <= conv_rises + 1;
  end
  always @(negedge adc_conv) t_conv_fall <= $time;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic s, input logic o, input logic [15:0] v);
    adc_val = v; cfg_single = s; cfg_odd = o;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!res_valid) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "lines in reset", {adc_conv, adc_sck, adc_sdi, busy, res_valid}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "lines after reset", {adc_conv, adc_sck, adc_sdi, busy, res_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      run_frame(VEC[i][17], VEC[i][16], VEC[i][15:0]);
      chk("R5", "code", res_code, VEC[i][15:0]);
      chk("R2", "conv high cycles", (t_conv_fall - t_conv_rise) / CLK_PERIOD, E_CONV);
      chk("R3", "conv fall to first rise", (t_first - t_conv_fall) / CLK_PERIOD, E_SETUP + E_HALF);
      chk("R4", "rise count", rise_cnt, 16);
      chk("R4", "sck period min", per_min / CLK_PERIOD, 2 * E_HALF);
      chk("R4", "sck period max", per_max / CLK_PERIOD, 2 * E_HALF);
      chk("R6", "sdi word", rxw, {VEC[i][17], VEC[i][16]});
      chk("R8", "last rise to valid", ($time - t_last) / CLK_PERIOD, E_HALF + E_HOLD);
      chk("R8", "busy at valid", busy, 0);
      chk("R7", "known", res_known, (i > 0));
      if (i > 0) chk("R7", "tag", {res_single, res_chan}, {VEC[i-1][17], VEC[i-1][16]});
      @(negedge clk);
      chk("R5", "valid one cycle", res_valid, 0);
    end

    begin : busy_ignore
      int base;
      base = conv_rises;
      adc_val = 16'h5A5A; cfg_single = 0; cfg_odd = 0;
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      repeat (120) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
      while (!res_valid) @(negedge clk);
      chk("R5", "code busy frame", res_code, 16'h5A5A);
      repeat (10) @(negedge clk);
      chk("R9", "busy after ignored start", busy, 0);
      chk("R9", "conv rises", conv_rises - base, 1);
    end

    begin : mid_reset
      @(negedge clk) start = 1;
      @(negedge clk) start = 0;
      while (!adc_sck) @(negedge clk);
      rst = 1; @(negedge clk);
      chk("R1", "lines in mid-frame reset", {adc_conv, adc_sck, adc_sdi, busy, res_valid}, 0);
      rst = 0; @(negedge clk);
      chk("R1", "lines after mid-frame reset", {adc_conv, adc_sck, busy}, 0);
      run_frame(1'b0, 1'b1, 16'hC0DE);
      chk("R7", "known after reset", res_known, 0);
      chk("R5", "code after reset", res_code, 16'hC0DE);
      run_frame(1'b1, 1'b0, 16'h0F0F);
      chk("R7", "known second", res_known, 1);
      chk("R7", "tag second", {res_single, res_chan}, 2'b01);
    end

    begin : auto_mode
      int base;
      @(negedge clk);
      base = conv_rises;
      auto_en = 1;
      while (conv_rises < base + 3) @(negedge clk);
      chk("R10", "auto interval", (t_conv_rise - t_prev_rise) / CLK_PERIOD, RATE);
      auto_en = 0;
      while (busy) @(negedge clk);
      repeat (RATE + 20) @(negedge clk);
      chk("R10", "no conversions when disabled", conv_rises - base, 3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule